// File: doc/BRIEF.md
# Programmable Supply Sequencing State Engine

This block steps a board through its power-up, power-down and fault handling by walking a stored state program. The state table is outside the block. The block presents the index of its current state on a lookup port and reads that state's definition back in the same cycle. Each definition carries an enable pattern for ten output rails and three condition terms. Each term watches a vector of logic inputs and supply-fault flags, and each names its own next state.

The sequence term must hold steadily for a programmed number of cycles before it moves the engine. The timeout term fires once the state has been occupied long enough, which lets the program build a watchdog on a toggling input. The monitor term either branches to a fault state or, when it is marked as a warning, raises an interrupt without leaving the state. Software can force a jump to any state. The current state index is also driven out for readback.

Top module: `supply_seq_engine`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) places the engine in state 0 and clears `enOut`, `warnIrq` and both internal counters. A software jump requested during reset has no effect.
- R2: `tblAddr` and `stateIdx` always equal the current state. `enOut` equals the output pattern of the state that was current at the previous edge, so it lags the state by one clock. The table word is packed MSB first as: output pattern (10 bits), sequence term, timeout term, monitor term, warning flag (1), sequence delay (8), timeout delay (8). Each term is packed as mask (8), polarity (8), AND-select (1), next state (6).
- R3: A term selects input bits with its mask. A masked bit is satisfied when it equals its polarity bit. With AND-select set, the term is true when every masked bit is satisfied, so an empty mask is always true. With AND-select clear, the term is true when any masked bit is satisfied, so an empty mask is never true.
- R4: A sequence term with delay D moves the engine to its target on the (D+1)-th consecutive rising edge at which the term is true and its masked inputs are unchanged from the previous edge. With D = 0 it moves on the first true edge.
- R5: The sequence hold count restarts from zero whenever the term is false, or when any of its masked inputs differs from its value at the previous edge, even if the term stays true.
- R6: A timeout term with delay D moves the engine to its target at an edge where the term is true and the state has been occupied for at least D edges since entry. An always-true timeout therefore fires on the (D+1)-th edge after entry.
- R7: A monitor term with the warning flag clear moves the engine to its target at the first edge at which the term is true.
- R8: A monitor term with the warning flag set drives `warnIrq` high one clock after the term is true, and low one clock after it is false. It causes no state change, and the timeout and sequence terms keep being evaluated.
- R9: When several branches are ready at one edge, the software jump wins, then the monitor branch, then the timeout branch, then the sequence branch.
- R10: `swJump` high at an edge loads `swTarget` as the new state. Any state change restarts both the hold count and the occupancy count.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| condIn | input | 8 | Logic inputs and supply-fault flags |
| swJump | input | 1 | Software jump request |
| swTarget | input | 6 | State to load on a software jump |
| tblAddr | output | 6 | State-table lookup index |
| tblData | input | 96 | State definition returned for `tblAddr` |
| enOut | output | 10 | Registered enable outputs |
| stateIdx | output | 6 | Current state readback |
| warnIrq | output | 1 | Warning interrupt |

## Verification
The bench builds the block at its default sizes: eight condition inputs, ten enables, six-bit state indices and eight-bit delays. These sizes let a small program reach every branch type. It covers a staged power-up and power-down, a fault branch, a warning that stays in place, and a watchdog kept alive by toggling. With delays of a few cycles, the edge where a hold completes can be hit exactly. So can a hold restarted by a swap between two OR inputs, and a 20-cycle timeout. Two dedicated states with every term always true expose the branch priority directly.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int IN_W  = 8;
  localparam int OUT_W = 10;
  localparam int ST_W  = 6;
  localparam int DLY_W = 8;

  typedef logic [ST_W-1:0]  stateT;
  typedef logic [DLY_W-1:0] delayT;

  typedef struct packed {
    logic [IN_W-1:0] mask;
    logic [IN_W-1:0] pol;
    logic            useAnd;
    stateT           next;
  } termT;

  typedef struct packed {
    logic [OUT_W-1:0] outPat;
    termT             seqT;
    termT             tmoT;
    termT             monT;
    logic             monWarn;
    delayT            seqDly;
    delayT            tmoDly;
  } entryT;

  localparam int ENTRY_W = $bits(entryT);

  // strobes from control to datapath
  typedef struct packed {
    logic clear;    // restart hold and occupancy counts
    logic entered;  // a branch was taken this cycle
  } strobeT;

  function automatic logic termHit(termT t, logic [IN_W-1:0] v);
    logic [IN_W-1:0] ok;
    ok = ~(v ^ t.pol) & t.mask;
    if (t.useAnd) return ok == t.mask;
    return |ok;
  endfunction
endpackage

// File: rtl/seq_datapath.sv
module seq_datapath
  import seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [IN_W-1:0]  condIn,
  input  entryT            entry,
  input  strobeT           strb,
  output logic             seqFire,
  output logic             tmoFire,
  output logic             monFire,
  output logic [OUT_W-1:0] enOut,
  output logic             warnIrq
);
  localparam delayT DLY_MAX = '1;
  localparam int    NUM_CNT = 2;

  logic [IN_W-1:0] prevIn;
  logic            seqCond, tmoCond, monCond, warnHit, seqChanged;
  delayT           effHold;
  delayT           cntQ   [NUM_CNT];
  delayT           cntBase[NUM_CNT];
  logic            cntRun [NUM_CNT];

  always_comb begin
    seqCond    = termHit(entry.seqT, condIn);
    tmoCond    = termHit(entry.tmoT, condIn);
    monCond    = termHit(entry.monT, condIn);
    seqChanged = |((condIn ^ prevIn) & entry.seqT.mask);
    effHold    = seqChanged ? '0 : cntQ[0];
    seqFire    = seqCond && (effHold >= entry.seqDly);
    tmoFire    = tmoCond && (cntQ[1] >= entry.tmoDly);
    monFire    = monCond && !entry.monWarn;
    warnHit    = monCond && entry.monWarn;
    cntBase[0] = effHold;
    cntRun[0]  = seqCond;
    cntBase[1] = cntQ[1];
    cntRun[1]  = 1'b1;
  end

  // counter 0: sequence hold, counter 1: state occupancy
  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (rst || strb.clear)   cntQ[g] <= '0;
      else if (!cntRun[g])     cntQ[g] <= '0;
      else if (cntBase[g] != DLY_MAX) cntQ[g] <= cntBase[g] + 1'b1;
      else                     cntQ[g] <= cntBase[g];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prevIn  <= '0;
      enOut   <= '0;
      warnIrq <= 1'b0;
    end else begin
      prevIn  <= condIn;
      enOut   <= entry.outPat;
      warnIrq <= warnHit;
    end
  end

  a_r1_reset_clears: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (enOut == '0) && !warnIrq && (cntQ[0] == '0) && (cntQ[1] == '0));

  a_r2_out_lags_state: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> enOut == $past(entry.outPat));

  a_r10_counts_restart: assert property (@(posedge clk) disable iff (rst)
    $past(strb.entered) |-> (cntQ[0] == '0) && (cntQ[1] == '0));

  a_r5_hold_drops: assert property (@(posedge clk) disable iff (rst)
    (!strb.clear && !seqCond) |=> cntQ[0] == '0);
endmodule

// File: rtl/seq_control.sv
module seq_control
  import seq_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   swJump,
  input  stateT  swTarget,
  input  logic   seqFire,
  input  logic   tmoFire,
  input  logic   monFire,
  input  stateT  seqNext,
  input  stateT  tmoNext,
  input  stateT  monNext,
  output stateT  curState,
  output strobeT strb
);
  stateT nxtState;
  logic  take;

  always_comb begin
    take     = 1'b1;
    nxtState = curState;
    if (swJump)       nxtState = swTarget;
    else if (monFire) nxtState = monNext;
    else if (tmoFire) nxtState = tmoNext;
    else if (seqFire) nxtState = seqNext;
    else              take     = 1'b0;
    strb.entered = take && !rst;
    strb.clear   = take || rst;
  end

  always_ff @(posedge clk) begin
    if (rst)       curState <= '0;
    else if (take) curState <= nxtState;
  end

  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> curState == '0);

  a_r9_sw_first: assert property (@(posedge clk) disable iff (rst)
    swJump |=> curState == $past(swTarget));

  a_r7_mon_over_tmo: assert property (@(posedge clk) disable iff (rst)
    (!swJump && monFire) |=> curState == $past(monNext));

  a_r6_tmo_over_seq: assert property (@(posedge clk) disable iff (rst)
    (!swJump && !monFire && tmoFire) |=> curState == $past(tmoNext));

  a_r4_idle_holds: assert property (@(posedge clk) disable iff (rst)
    (!swJump && !monFire && !tmoFire && !seqFire) |=> $stable(curState));
endmodule

// File: rtl/supply_seq_engine.sv
module supply_seq_engine
  import seq_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic [IN_W-1:0]     condIn,
  input  logic                swJump,
  input  logic [ST_W-1:0]     swTarget,
  output logic [ST_W-1:0]     tblAddr,
  input  logic [ENTRY_W-1:0]  tblData,
  output logic [OUT_W-1:0]    enOut,
  output logic [ST_W-1:0]     stateIdx,
  output logic                warnIrq
);
  entryT  entry;
  strobeT strb;
  stateT  curState;
  logic   seqFire, tmoFire, monFire;

  assign entry    = entryT'(tblData);
  assign tblAddr  = curState;
  assign stateIdx = curState;

  seq_datapath dp_i (
    .clk     (clk),
    .rst     (rst),
    .condIn  (condIn),
    .entry   (entry),
    .strb    (strb),
    .seqFire (seqFire),
    .tmoFire (tmoFire),
    .monFire (monFire),
    .enOut   (enOut),
    .warnIrq (warnIrq)
  );

  seq_control ctl_i (
    .clk      (clk),
    .rst      (rst),
    .swJump   (swJump),
    .swTarget (swTarget),
    .seqFire  (seqFire),
    .tmoFire  (tmoFire),
    .monFire  (monFire),
    .seqNext  (entry.seqT.next),
    .tmoNext  (entry.tmoT.next),
    .monNext  (entry.monT.next),
    .curState (curState),
    .strb     (strb)
  );
endmodule

// File: tb/supply_seq_engine_tb.sv
module supply_seq_engine_tb_top;
  import seq_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_VEC    = 34;

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic [IN_W-1:0]     condIn = '0;
  logic                swJump = 1'b0;
  logic [ST_W-1:0]     swTarget = '0;
  logic [ST_W-1:0]     tblAddr;
  logic [ENTRY_W-1:0]  tblData;
  logic [OUT_W-1:0]    enOut;
  logic [ST_W-1:0]     stateIdx;
  logic                warnIrq;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  supply_seq_engine dut_i (
    .clk(clk), .rst(rst), .condIn(condIn), .swJump(swJump), .swTarget(swTarget),
    .tblAddr(tblAddr), .tblData(tblData), .enOut(enOut), .stateIdx(stateIdx),
    .warnIrq(warnIrq)
  );

  function automatic termT tm(logic [7:0] m, logic [7:0] p, logic a, stateT n);
    termT t;
    t.mask = m; t.pol = p; t.useAnd = a; t.next = n;
    return t;
  endfunction

  // test program; unlisted terms are zero (OR with empty mask: never true)
  function automatic entryT prog(stateT s);
    entryT e;
    e = '0;
    case (s)
      6'd0: begin e.seqT = tm(8'h01, 8'h01, 1'b1, 6'd1); e.seqDly = 8'd3; end
      6'd1: begin
        e.outPat = 10'h001;
        e.seqT = tm(8'h02, 8'h02, 1'b1, 6'd2); e.seqDly = 8'd2;
        e.tmoT = tm(8'h00, 8'h00, 1'b1, 6'd5); e.tmoDly = 8'd20;
        e.monT = tm(8'h80, 8'h80, 1'b0, 6'd5);
      end
      6'd2: begin
        e.outPat = 10'h003;
        e.seqT = tm(8'h0C, 8'h0C, 1'b0, 6'd3); e.seqDly = 8'd4;
        e.monT = tm(8'h80, 8'h80, 1'b0, 6'd5);
      end
      6'd3: begin
        e.outPat = 10'h3FF;
        e.seqT = tm(8'h01, 8'h00, 1'b1, 6'd4);
        e.monT = tm(8'h40, 8'h40, 1'b0, 6'd0); e.monWarn = 1'b1;
      end
      6'd4: begin e.outPat = 10'h001; e.seqT = tm(8'h00, 8'h00, 1'b1, 6'd0); e.seqDly = 8'd2; end
      6'd5: begin e.seqT = tm(8'h20, 8'h20, 1'b1, 6'd0); end
      6'd6: begin
        e.outPat = 10'h200;
        e.seqT = tm(8'h10, 8'h10, 1'b1, 6'd7);
        e.tmoT = tm(8'h00, 8'h00, 1'b1, 6'd5); e.tmoDly = 8'd5;
      end
      6'd7: begin e.outPat = 10'h200; e.seqT = tm(8'h10, 8'h00, 1'b1, 6'd6); end
      6'd8: begin
        e.seqT = tm(8'h00, 8'h00, 1'b1, 6'd12);
        e.tmoT = tm(8'h00, 8'h00, 1'b1, 6'd10);
      end
      6'd9: begin
        e.seqT = tm(8'h00, 8'h00, 1'b1, 6'd12);
        e.tmoT = tm(8'h00, 8'h00, 1'b1, 6'd10);
        e.monT = tm(8'h00, 8'h00, 1'b1, 6'd11);
      end
      6'd11: e.outPat = 10'h0F0;
      default: e = '0;
    endcase
    return e;
  endfunction

  assign tblData = prog(tblAddr);

  typedef struct packed {
    logic [7:0] inV;
    logic       sw;
    logic [5:0] swS;
    logic [7:0] waitN;
    logic [5:0] expS;
    logic [9:0] expO;
    logic       expI;
    logic [3:0] req;
  } vecT;

  localparam vecT VEC [NUM_VEC] = '{
    '{8'h01, 1'b0, 6'd0, 8'd3,  6'd0,  10'h000, 1'b0, 4'd4},  // R4 hold not yet done
    '{8'h01, 1'b0, 6'd0, 8'd1,  6'd1,  10'h000, 1'b0, 4'd4},  // R4 moves on 4th edge
    '{8'h01, 1'b0, 6'd0, 8'd1,  6'd1,  10'h001, 1'b0, 4'd2},  // R2 output lag
    '{8'h03, 1'b0, 6'd0, 8'd2,  6'd1,  10'h001, 1'b0, 4'd4},  // R4
    '{8'h01, 1'b0, 6'd0, 8'd1,  6'd1,  10'h001, 1'b0, 4'd5},  // R5 term false
    '{8'h03, 1'b0, 6'd0, 8'd2,  6'd1,  10'h001, 1'b0, 4'd5},  // R5 restarted
    '{8'h03, 1'b0, 6'd0, 8'd1,  6'd2,  10'h001, 1'b0, 4'd4},  // R4
    '{8'h07, 1'b0, 6'd0, 8'd3,  6'd2,  10'h003, 1'b0, 4'd3},  // R3 OR term
    '{8'h0B, 1'b0, 6'd0, 8'd4,  6'd2,  10'h003, 1'b0, 4'd5},  // R5 masked swap restarts
    '{8'h0B, 1'b0, 6'd0, 8'd1,  6'd3,  10'h003, 1'b0, 4'd5},  // R5
    '{8'h0B, 1'b0, 6'd0, 8'd1,  6'd3,  10'h3FF, 1'b0, 4'd2},  // R2
    '{8'h4B, 1'b0, 6'd0, 8'd1,  6'd3,  10'h3FF, 1'b1, 4'd8},  // R8 warning stays
    '{8'h0B, 1'b0, 6'd0, 8'd1,  6'd3,  10'h3FF, 1'b0, 4'd8},  // R8 warning clears
    '{8'h0A, 1'b0, 6'd0, 8'd1,  6'd4,  10'h3FF, 1'b0, 4'd3},  // R3 low polarity, delay 0
    '{8'h0A, 1'b0, 6'd0, 8'd1,  6'd4,  10'h001, 1'b0, 4'd2},  // R2
    '{8'h0A, 1'b0, 6'd0, 8'd2,  6'd0,  10'h001, 1'b0, 4'd3},  // R3 empty AND true
    '{8'h0A, 1'b0, 6'd0, 8'd1,  6'd0,  10'h000, 1'b0, 4'd2},  // R2
    '{8'h84, 1'b1, 6'd2, 8'd1,  6'd2,  10'h000, 1'b0, 4'd10}, // R10 software jump
    '{8'h84, 1'b0, 6'd0, 8'd1,  6'd5,  10'h003, 1'b0, 4'd7},  // R7 fault branch
    '{8'h84, 1'b0, 6'd0, 8'd1,  6'd5,  10'h000, 1'b0, 4'd7},  // R7
    '{8'h20, 1'b0, 6'd0, 8'd1,  6'd0,  10'h000, 1'b0, 4'd4},  // R4
    '{8'h00, 1'b1, 6'd8, 8'd1,  6'd8,  10'h000, 1'b0, 4'd10}, // R10
    '{8'h00, 1'b0, 6'd0, 8'd1,  6'd10, 10'h000, 1'b0, 4'd9},  // R9 timeout over sequence
    '{8'h00, 1'b1, 6'd9, 8'd1,  6'd9,  10'h000, 1'b0, 4'd10}, // R10
    '{8'h00, 1'b0, 6'd0, 8'd1,  6'd11, 10'h000, 1'b0, 4'd9},  // R9 monitor over timeout
    '{8'h00, 1'b1, 6'd1, 8'd1,  6'd1,  10'h0F0, 1'b0, 4'd10}, // R10
    '{8'h00, 1'b0, 6'd0, 8'd20, 6'd1,  10'h001, 1'b0, 4'd6},  // R6 not yet
    '{8'h00, 1'b0, 6'd0, 8'd1,  6'd5,  10'h001, 1'b0, 4'd6},  // R6 timeout fires
    '{8'h00, 1'b1, 6'd6, 8'd1,  6'd6,  10'h000, 1'b0, 4'd10}, // R10
    '{8'h00, 1'b0, 6'd0, 8'd2,  6'd6,  10'h200, 1'b0, 4'd6},  // R6
    '{8'h10, 1'b0, 6'd0, 8'd1,  6'd7,  10'h200, 1'b0, 4'd6},  // R6 watchdog toggle
    '{8'h00, 1'b0, 6'd0, 8'd1,  6'd6,  10'h200, 1'b0, 4'd10}, // R10 re-entry restarts
    '{8'h00, 1'b0, 6'd0, 8'd5,  6'd6,  10'h200, 1'b0, 4'd6},  // R6
    '{8'h00, 1'b0, 6'd0, 8'd1,  6'd5,  10'h200, 1'b0, 4'd6}   // R6 watchdog expiry
  };

  task automatic checkAll(int reqN, logic [5:0] eS, logic [9:0] eO, logic eI);
    nChecks++;
    if (stateIdx !== eS || tblAddr !== eS || enOut !== eO || warnIrq !== eI) begin
      nFails++;
      $display("FAIL R%0d: state=%0d addr=%0d en=%h irq=%b expected state=%0d en=%h irq=%b",
               reqN, stateIdx, tblAddr, enOut, warnIrq, eS, eO, eI);
    end
  endtask

  task automatic finish();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checkAll(1, 6'd0, 10'h000, 1'b0);  // R1 reset state
    rst = 1'b0;
    for (int i = 0; i < NUM_VEC; i++) begin
      condIn   = VEC[i].inV;
      swJump   = VEC[i].sw;
      swTarget = VEC[i].swS;
      for (int k = 0; k < int'(VEC[i].waitN); k++) @(negedge clk);
      checkAll(int'(VEC[i].req), VEC[i].expS, VEC[i].expO, VEC[i].expI);
    end
    // R1 reset in the middle of a run, with a jump request that must be ignored
    rst = 1'b1; swJump = 1'b1; swTarget = 6'd3; condIn = 8'h00;
    @(negedge clk);
    checkAll(1, 6'd0, 10'h000, 1'b0);
    @(negedge clk);
    checkAll(1, 6'd0, 10'h000, 1'b0);
    rst = 1'b0; swJump = 1'b0;
    @(negedge clk);
    checkAll(2, 6'd0, 10'h000, 1'b0);  // R2 state 0 pattern after release
    finished = 1'b1;
    finish();
  end
endmodule